// File: doc/BRIEF.md
# Multi-Depth Pixel Serializer with Fixed Palette

This block sits at the back end of a raster display pipeline. It takes one screen byte at a time and sends it out as a run of colour indices. The pixel depth is selectable: a byte holds eight 1-bit pixels, four 2-bit pixels or two 4-bit pixels. Each index is mapped through a fixed eight-colour palette, repeated over sixteen indices, to a 3-bit RGB value. A horizontal stretch setting holds each pixel for 1, 2 or 4 clocks. The stretch is paced by a one-hot phase counter that the surrounding fetch logic supplies.

In the 2- and 4-bit modes the bits of one pixel are spread across the byte instead of sitting side by side. When the byte is loaded it is reordered so that every pixel ends up in the top bits of an internal shift register. A second register, the pending mask, marks how many pixels are still to be shown.

Control is a two-state machine. In EMPTY nothing is pending and the output is black. In DRAW a byte is being shown. The transitions are:

- LOAD (EMPTY to DRAW, or DRAW to DRAW) on a byte strobe.
- DRAIN (DRAW to EMPTY) when the last pixel is advanced past and no new byte arrives.
- HOLD in every other case.

Top module: `pxser_top`

## Requirements
- R1: While reset is asserted and after its release, `rgb` is 000 and no pixel is pending until the first byte strobe.
- R2: With `depth_sel`=0 (1 bit per pixel) a byte yields 8 pixels, and pixel i (from 0) is byte bit 7−i.
- R3: With `depth_sel`=1 (2 bits per pixel) a byte yields 4 pixels, and pixel i has high bit = byte bit 7−i and low bit = byte bit 3−i.
- R4: With `depth_sel`=2 (4 bits per pixel) a byte yields 2 pixels, and pixel i has bits 3..0 = byte bits 7−i, 5−i, 3−i, 1−i. The value 3 is treated as 1 bit per pixel.
- R5: `rgb` is registered. It shows, one clock later, the pixel that was current at an edge. Index bit 0 drives `rgb[0]` (red), bit 1 drives `rgb[1]` (green) and bit 2 drives `rgb[2]` (blue). Index bit 3 has no effect.
- R6: The serializer advances to the next pixel at an edge as follows:
  - `scale_sel`=0: every edge.
  - `scale_sel`=1: edges where the one-hot `phase` has bit 0, 2, 4 or 6 set.
  - `scale_sel`=2: edges where `phase` has bit 0 or 4 set.
  - The value 3 behaves as 0.
  - Between advances the current pixel is held.
- R7: Once the last pixel of a byte has been advanced past, `rgb` is 000 until the next byte is loaded.
- R8: While `active` is low at an edge, the `rgb` produced by that edge is 000. Pixels keep advancing at their normal pace.
- R9: A byte strobe while pixels are still pending replaces the remaining pixels, and output restarts at pixel 0 of the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| depth_sel | input | 2 | Bits per pixel: 0 = 1, 1 = 2, 2 = 4 |
| scale_sel | input | 2 | Pixel stretch: 0 = ×1, 1 = ×2, 2 = ×4 |
| pix_byte | input | 8 | Screen byte to serialize |
| pix_vld | input | 1 | Load strobe for `pix_byte` |
| active | input | 1 | High inside the visible window |
| phase | input | 8 | One-hot phase within the fetch period |
| rgb | output | 3 | Colour output {blue, green, red} |

## Verification
The checker enforces five properties on every cycle:
- An empty pending mask is followed by black output.
- An inactive window is followed by black output.
- A load leaves exactly one pending-mask bit at the lowest position.
- The mask never has more than one bit set.
- The shift register is stable when there is neither an advance nor a load.

The bit reordering for each depth, the exact stretch pattern against the phase, palette wrap-around and the restart on an overlapping load can only be shown by the bench's scenarios. The bench compares them, one clock at a time, against a queue-based model that decodes each byte directly from its bit positions.

// File: rtl/pxser_pkg.sv
package pxser_pkg;

    localparam int IDX_W  = 4;
    localparam int RGB_W  = 3;
    localparam int N_IDX  = 1 << IDX_W;
    localparam int N_COL  = 1 << RGB_W;

    typedef enum logic [1:0] {
        DEPTH_1 = 2'd0,
        DEPTH_2 = 2'd1,
        DEPTH_4 = 2'd2,
        DEPTH_X = 2'd3
    } px_depth_e;

    typedef enum logic [1:0] {
        STRETCH_1 = 2'd0,
        STRETCH_2 = 2'd1,
        STRETCH_4 = 2'd2,
        STRETCH_X = 2'd3
    } px_stretch_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_DRAW  = 1'b1
    } px_state_e;

endpackage

// File: rtl/pxser_unpack.sv
module pxser_unpack
    import pxser_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] raw,
    input  px_depth_e         depth,
    output logic [BYTE_W-1:0] ordered
);
    localparam int N_VAR = 3;

    logic [BYTE_W-1:0] variant [N_VAR];

    // Variant k serves 2**k bits per pixel: pixel i lands in the top slots of
    // its group; bit b of that pixel is fetched at stride BYTE_W/D.
    for (genvar k = 0; k < N_VAR; k++) begin : g_depth
        localparam int D      = 1 << k;
        localparam int NPIX   = BYTE_W / D;
        localparam int STRIDE = BYTE_W / D;
        for (genvar i = 0; i < NPIX; i++) begin : g_pix
            for (genvar b = 0; b < D; b++) begin : g_bit
                assign variant[k][BYTE_W-1-i*D-(D-1-b)] = raw[BYTE_W-1-i-(D-1-b)*STRIDE];
            end
        end
    end

    always_comb begin
        unique case (depth)
            DEPTH_2: ordered = variant[1];
            DEPTH_4: ordered = variant[2];
            default: ordered = variant[0];
        endcase
    end
endmodule

// File: rtl/pxser_pace.sv
module pxser_pace
    import pxser_pkg::*;
#(
    parameter int PHASES = 8
) (
    input  px_stretch_e       stretch,
    input  logic [PHASES-1:0] phase,
    output logic              adv
);
    function automatic logic [PHASES-1:0] every_nth(int n);
        logic [PHASES-1:0] m;
        for (int p = 0; p < PHASES; p++) begin
            m[p] = ((p % n) == 0);
        end
        return m;
    endfunction

    localparam logic [PHASES-1:0] SEL_2 = every_nth(2);
    localparam logic [PHASES-1:0] SEL_4 = every_nth(4);

    always_comb begin
        unique case (stretch)
            STRETCH_2: adv = |(phase & SEL_2);
            STRETCH_4: adv = |(phase & SEL_4);
            default:   adv = 1'b1;
        endcase
    end
endmodule

// File: rtl/pxser_palette.sv
module pxser_palette
    import pxser_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [RGB_W-1:0] colour
);
    function automatic logic [RGB_W-1:0] base_colour(int k);
        logic [RGB_W-1:0] c;
        c[0] = k[0];    // red
        c[1] = k[1];    // green
        c[2] = k[2];    // blue
        return c;
    endfunction

    logic [RGB_W-1:0] lut [N_IDX];

    always_comb begin
        for (int k = 0; k < N_IDX; k++) begin
            lut[k] = base_colour(k % N_COL);
        end
    end

    assign colour = lut[idx];
endmodule

// File: rtl/pxser_top.sv
module pxser_top
    import pxser_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PHASES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        depth_sel,
    input  logic [1:0]        scale_sel,
    input  logic [BYTE_W-1:0] pix_byte,
    input  logic              pix_vld,
    input  logic              active,
    input  logic [PHASES-1:0] phase,
    output logic [RGB_W-1:0]  rgb
);
    localparam logic [BYTE_W-1:0] MASK_FIRST = BYTE_W'(1);

    px_depth_e         depth;
    px_stretch_e       stretch;
    px_state_e         state_q, state_d;
    logic [BYTE_W-1:0] shreg_q, mask_q;
    logic [BYTE_W-1:0] ordered, shreg_rot, mask_adv;
    logic              adv, last;
    logic [IDX_W-1:0]  cur_idx;
    logic [RGB_W-1:0]  pal_rgb, rgb_q;

    assign depth   = px_depth_e'(depth_sel);
    assign stretch = px_stretch_e'(scale_sel);

    pxser_unpack #(.BYTE_W(BYTE_W)) u_unpack (
        .raw     (pix_byte),
        .depth   (depth),
        .ordered (ordered)
    );

    pxser_pace #(.PHASES(PHASES)) u_pace (
        .stretch (stretch),
        .phase   (phase),
        .adv     (adv)
    );

    pxser_palette u_pal (
        .idx    (cur_idx),
        .colour (pal_rgb)
    );

    // Per-depth rotate, zero-fill mask shift and index pick.
    always_comb begin
        unique case (depth)
            DEPTH_2: begin
                shreg_rot = {shreg_q[BYTE_W-3:0], shreg_q[BYTE_W-1:BYTE_W-2]};
                mask_adv  = {mask_q[BYTE_W-3:0], 2'b00};
                cur_idx   = {{(IDX_W-2){1'b0}}, shreg_q[BYTE_W-1:BYTE_W-2]};
            end
            DEPTH_4: begin
                shreg_rot = {shreg_q[BYTE_W-5:0], shreg_q[BYTE_W-1:BYTE_W-4]};
                mask_adv  = {mask_q[BYTE_W-5:0], 4'b0000};
                cur_idx   = shreg_q[BYTE_W-1:BYTE_W-4];
            end
            default: begin
                shreg_rot = {shreg_q[BYTE_W-2:0], shreg_q[BYTE_W-1]};
                mask_adv  = {mask_q[BYTE_W-2:0], 1'b0};
                cur_idx   = {{(IDX_W-1){1'b0}}, shreg_q[BYTE_W-1]};
            end
        endcase
    end

    assign last = (mask_adv == '0);

    // Transitions: LOAD, DRAIN, HOLD.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (pix_vld) state_d = ST_DRAW;
            ST_DRAW: begin
                if (pix_vld)          state_d = ST_DRAW;
                else if (adv && last) state_d = ST_EMPTY;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Pixel datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            mask_q  <= '0;
        end else if (pix_vld) begin
            shreg_q <= ordered;
            mask_q  <= MASK_FIRST;
        end else if (state_q == ST_DRAW && adv) begin
            shreg_q <= shreg_rot;
            mask_q  <= mask_adv;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rgb_q <= '0;
        else        rgb_q <= (state_q == ST_DRAW && active) ? pal_rgb : '0;
    end

    assign rgb = rgb_q;
endmodule

// File: rtl/pxser_chk.sv
module pxser_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_vld,
    input logic              active,
    input logic              adv,
    input logic [2:0]        rgb,
    input logic [BYTE_W-1:0] mask_q,
    input logic [BYTE_W-1:0] shreg_q
);
    a_r7_idle_black: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> (rgb == 3'b000));

    a_r8_inactive_black: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (rgb == 3'b000));

    a_r9_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |=> (mask_q == BYTE_W'(1)));

    a_r6_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_q));

    a_r6_hold_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_vld && !adv) |=> $stable(shreg_q));
endmodule

bind pxser_top pxser_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pix_vld (pix_vld),
    .active  (active),
    .adv     (adv),
    .rgb     (rgb),
    .mask_q  (mask_q),
    .shreg_q (shreg_q)
);

// File: tb/sim_pxser_top.sv
module sim_pxser_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] depth_sel = 2'd0;
    logic [1:0] scale_sel = 2'd0;
    logic [7:0] pix_byte = 8'h00;
    logic       pix_vld = 1'b0;
    logic       active = 1'b1;
    logic [7:0] phase = 8'h01;
    logic [2:0] rgb;

    int checks = 0;
    int errors = 0;
    int ph = 0;
    int pend[$];
    bit done = 0;

    always #2 clk = ~clk;

    pxser_top u0 (
        .clk(clk), .rst_n(rst_n), .depth_sel(depth_sel), .scale_sel(scale_sel),
        .pix_byte(pix_byte), .pix_vld(pix_vld), .active(active), .phase(phase), .rgb(rgb)
    );

    task automatic check(string tag, logic [2:0] got, logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: rgb=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // Pixel list straight from the stated bit positions.
    function automatic void decode(logic [7:0] b, int ds);
        pend.delete();
        if (ds == 1) begin
            for (int i = 0; i < 4; i++) pend.push_back({b[7-i], b[3-i]});
        end else if (ds == 2) begin
            for (int i = 0; i < 2; i++) pend.push_back({b[7-i], b[5-i], b[3-i], b[1-i]});
        end else begin
            for (int i = 0; i < 8; i++) pend.push_back(int'(b[7-i]));
        end
    endfunction

    function automatic bit moves(int ss, int p);
        if (ss == 1) return (p % 2) == 0;
        if (ss == 2) return (p % 4) == 0;
        return 1'b1;
    endfunction

    // Called at a falling edge: drive, predict, cross one rising edge, compare.
    task automatic step(bit vld, logic [7:0] b, bit act, string tag);
        logic [2:0] exp;
        pix_vld  = vld;
        pix_byte = b;
        active   = act;
        phase    = 8'(1 << ph);
        exp = (pend.size() > 0 && act) ? 3'(pend[0] & 7) : 3'b000;
        if (pend.size() > 0 && moves(int'(scale_sel), ph)) void'(pend.pop_front());
        if (vld) decode(b, int'(depth_sel));
        @(posedge clk);
        @(negedge clk);
        check(tag, rgb, exp);
        ph = (ph + 1) % 8;
    endtask

    task automatic idle(int n, string tag);
        for (int k = 0; k < n; k++) step(1'b0, 8'h00, 1'b1, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", rgb, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", rgb, 3'b000);
        idle(3, "R1");

        // 1 bpp, x1
        depth_sel = 2'd0; scale_sel = 2'd0;
        step(1'b1, 8'hA5, 1'b1, "R2");
        idle(10, "R2_R7");

        // 2 bpp, x2
        depth_sel = 2'd1; scale_sel = 2'd1;
        step(1'b1, 8'hC9, 1'b1, "R3");
        idle(12, "R3_R6");
        step(1'b1, 8'h36, 1'b1, "R3");
        idle(12, "R7");

        // 4 bpp, x4, palette wrap (indices 15 and 12)
        depth_sel = 2'd2; scale_sel = 2'd2;
        step(1'b1, 8'hFA, 1'b1, "R4");
        idle(12, "R5");
        step(1'b1, 8'h5C, 1'b1, "R4");
        idle(12, "R6");

        // 4 bpp, x1 with window toggling
        scale_sel = 2'd0;
        step(1'b1, 8'h6B, 1'b1, "R8");
        step(1'b0, 8'h00, 1'b0, "R8");
        step(1'b0, 8'h00, 1'b1, "R8");
        step(1'b1, 8'hD7, 1'b0, "R8");
        step(1'b0, 8'h00, 1'b0, "R8");
        step(1'b0, 8'h00, 1'b1, "R8");
        idle(6, "R8");

        // Overlapping load
        depth_sel = 2'd0;
        step(1'b1, 8'hFF, 1'b1, "R9");
        idle(3, "R9");
        step(1'b1, 8'h0F, 1'b1, "R9");
        idle(10, "R9");

        // Steady fetch cadence, 2 bpp x2: a byte every 8 clocks
        depth_sel = 2'd1; scale_sel = 2'd1;
        while (ph != 0) step(1'b0, 8'h00, 1'b1, "R6");
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 8'(8'h3C + 8'(k * 37)), 1'b1, "R6");
            idle(7, "R6");
        end
        idle(10, "R7");

        // Encoding 3 of both selects
        depth_sel = 2'd3; scale_sel = 2'd3;
        step(1'b1, 8'h93, 1'b1, "R4");
        idle(10, "R6");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule